// File: doc/BRIEF.md
# Bypassable 16-bit Clock-Enable Divider

This block turns a stream of parent clock-enable pulses into a slower stream of divided clock-enable pulses for an audio interface. The divider is run from one 32-bit control word. Its top half holds an integer divisor. Its two lowest bits must both be set before the divider counts. Everything runs on a single system clock. The parent rate and the output rate exist only as single-cycle enable pulses.

A divisor of 0 or 1 selects pass-through: every parent pulse reappears on the output one cycle later. A divisor of 2 or more, with both enable bits set, produces one output pulse for every N parent pulses. With a divisor of 2 or more and the enable bits not both set, the output stays low. Writing an all-zero word turns division off, which returns the block to pass-through. A write that sets both enable bits while carrying a divisor below 2 is discarded, so the stored word is left as it was.

Top module: `audclk_div`

## Requirements
- R1: After reset the stored control word reads as 0 and the divided output is low.
- R2: An accepted write stores all 32 bits, and the read port returns that word from the next cycle on.
- R3: When the divisor field (bits 31:16) is 0 or 1, the output equals the parent enable of the previous cycle, whatever the enable bits (bits 1:0) hold.
- R4: When the divisor field is N (N from 2 up) and bits 1:0 are 2'b11, exactly one output pulse is produced for every N parent pulses.
- R5: When the divisor field is 2 or more and bits 1:0 are not 2'b11, the output stays low.
- R6: Writing the all-zero word stops division and puts the block in pass-through.
- R7: A write whose bits 1:0 are 2'b11 and whose divisor field is below 2 is ignored, and the stored word keeps its previous value.
- R8: Every accepted write restarts the count from zero. In divide mode the first output pulse appears in the cycle after the N-th parent pulse that follows the write.
- R9: The largest divisor, 0xFFFF, gives exactly one output pulse per 65535 parent pulses.
- R10: Cycles in which the parent enable is low do not advance the count and never produce an output pulse in divide mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word |
| parent_ce | input | 1 | Parent clock-enable pulse |
| div_ce | output | 1 | Divided clock-enable pulse, registered |

## Verification
The bench builds the block with its default widths: a 32-bit word and a 16-bit divisor field. At these widths the full divisor range can be reached, so 0xFFFF is run to completion and checked for a single pulse in the last of its 65535 parent cycles. Parent pulses are spaced one, two and three cycles apart to show that the count follows parent pulses rather than clock cycles. Directed cases check the exact cycle of the first pulse, a restart written in mid-count, and writes that are dropped.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int EN_W = 2;
  localparam logic [EN_W-1:0] EN_RUN = 2'b11;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_HOLD = 2'd2
  } div_mode_e;
endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl import audclk_pkg::*; #(
  parameter int REG_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] word_q,
  output logic [DIV_W-1:0] divisor,
  output logic [EN_W-1:0]  en_bits,
  output logic             restart
);
  localparam int DIV_LSB = REG_W - DIV_W;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] wr_div;
  logic             drop;

  assign wr_div  = wr_data[REG_W-1:DIV_LSB];
  assign drop    = (wr_data[EN_W-1:0] == EN_RUN) && (wr_div < DIV_MIN);
  assign restart = wr_en && !drop;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (restart) word_q <= wr_data;
  end

  assign divisor = word_q[REG_W-1:DIV_LSB];
  assign en_bits = word_q[EN_W-1:0];
endmodule

// File: rtl/audclk_count.sv
module audclk_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] divisor,
  output logic             hit
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = divisor - DIV_W'(1);
  assign hit  = run && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (hit)               cnt <= '0;
    else if (tick)              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/audclk_div.sv
module audclk_div import audclk_pkg::*; #(
  parameter int REG_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             parent_ce,
  output logic             div_ce
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] divisor;
  logic [EN_W-1:0]  en_bits;
  logic             restart;
  logic             hit;
  div_mode_e        mode;

  audclk_ctrl #(.REG_W(REG_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .word_q  (rd_data),
    .divisor (divisor),
    .en_bits (en_bits),
    .restart (restart)
  );

  always_comb begin
    if (divisor < DIV_MIN)     mode = MODE_PASS;
    else if (en_bits == EN_RUN) mode = MODE_RUN;
    else                        mode = MODE_HOLD;
  end

  audclk_count #(.DIV_W(DIV_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .run     (mode == MODE_RUN),
    .tick    (parent_ce),
    .divisor (divisor),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) div_ce <= 1'b0;
    else begin
      case (mode)
        MODE_PASS: div_ce <= parent_ce;
        MODE_RUN:  div_ce <= hit;
        default:   div_ce <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/audclk_chk.sv
module audclk_chk #(
  parameter int REG_W = 32,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             parent_ce,
  input logic             div_ce
);
  localparam int DIV_LSB = REG_W - DIV_W;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] rd_div, wr_div;
  logic             rd_run, wr_drop;

  assign rd_div  = rd_data[REG_W-1:DIV_LSB];
  assign wr_div  = wr_data[REG_W-1:DIV_LSB];
  assign rd_run  = (rd_data[1:0] == 2'b11);
  assign wr_drop = (wr_data[1:0] == 2'b11) && (wr_div < DIV_MIN);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (rd_data == '0 && !div_ce)); // R1
  AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_drop) |=> (rd_data == $past(wr_data))); // R2
  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_div < DIV_MIN) |=> (div_ce == $past(parent_ce))); // R3
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_div >= DIV_MIN && !rd_run) |=> !div_ce); // R5
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_drop) |=> $stable(rd_data)); // R7
  AST_NO_PARENT: assert property (@(posedge clk) disable iff (rst)
    (rd_div >= DIV_MIN && !parent_ce) |=> !div_ce); // R10
endmodule

bind audclk_div audclk_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .parent_ce (parent_ce),
  .div_ce    (div_ce)
);

// File: tb/tb_audclk_div.sv
module tb_audclk_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        parent_ce = 1'b0;
  logic        div_ce;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  audclk_div dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .parent_ce(parent_ce), .div_ce(div_ce)
  );

  // {control word, parent pulse count, cycles per parent pulse}
  localparam logic [47:0] VEC [10] = '{
    {32'h0000_0000, 8'd10, 8'd1},
    {32'h0001_0000, 8'd7,  8'd2},
    {32'h0000_0002, 8'd5,  8'd1},
    {32'h0002_0003, 8'd10, 8'd1},
    {32'h0003_0003, 8'd10, 8'd3},
    {32'h0005_0003, 8'd12, 8'd2},
    {32'h0004_0001, 8'd12, 8'd1},
    {32'h0004_0002, 8'd12, 8'd1},
    {32'h0007_0000, 8'd9,  8'd1},
    {32'h000A_0003, 8'd30, 8'd1}
  };

  function automatic int expect_pulses(input logic [31:0] w, input int k);
    int d = int'(w[31:16]);
    if (d < 2) return k;
    if (w[1:0] == 2'b11) return k / d;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // k parent pulses spaced p cycles, plus drain; returns pulse count
  task automatic run_parent(input int k, input int p, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      for (int j = 0; j < p; j++) begin
        parent_ce = (j == 0);
        @(negedge clk);
        if (div_ce) seen++;
      end
    end
    parent_ce = 1'b0;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      if (div_ce) seen++;
    end
  endtask

  initial begin
    int seen;
    int first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0, "R1 reset word", rd_data, 0);
    check(div_ce == 1'b0, "R1 reset output", div_ce, 0);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 10; v++) begin
      logic [31:0] w = VEC[v][47:16];
      int k = int'(VEC[v][15:8]);
      int p = int'(VEC[v][7:0]);
      write_word(w);
      check(rd_data == w, "R2 readback", rd_data, w);
      run_parent(k, p, seen);
      check(seen == expect_pulses(w, k), "R3/R4/R5/R6/R10 pulse count", seen, expect_pulses(w, k));
    end

    // R7: dropped writes
    write_word(32'h0005_0003);
    write_word(32'h0001_0003);
    check(rd_data == 32'h0005_0003, "R7 divisor 1 with enables", rd_data, 32'h0005_0003);
    write_word(32'h0000_0003);
    check(rd_data == 32'h0005_0003, "R7 divisor 0 with enables", rd_data, 32'h0005_0003);

    // R8: first pulse lands after the 4th parent pulse
    write_word(32'h0004_0003);
    first = 0;
    parent_ce = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (div_ce && first == 0) first = i;
    end
    parent_ce = 1'b0;
    check(first == 4, "R8 first pulse cycle", first, 4);
    // R8: restart in mid-count
    write_word(32'h0004_0003);
    parent_ce = 1'b1;
    repeat (2) @(negedge clk);
    parent_ce = 1'b0;
    write_word(32'h0004_0003);
    first = 0;
    parent_ce = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (div_ce && first == 0) first = i;
    end
    parent_ce = 1'b0;
    check(first == 4, "R8 restart after write", first, 4);

    // R6: zero word after dividing returns to pass-through
    write_word(32'h0000_0000);
    run_parent(6, 1, seen);
    check(seen == 6, "R6 zero word pass-through", seen, 6);

    // R9: largest divisor
    write_word(32'hFFFF_0003);
    first = 0; seen = 0;
    parent_ce = 1'b1;
    for (int i = 1; i <= 65536; i++) begin
      @(negedge clk);
      if (div_ce) begin seen++; if (first == 0) first = i; end
    end
    parent_ce = 1'b0;
    check(first == 65535, "R9 pulse position", first, 65535);
    check(seen == 1, "R9 pulse count", seen, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule